// File: doc/BRIEF.md
# Cumulative-Sum Noise-Floor Boundary Detector

This block finds where the noise floor ends in a list of channel energies that has already been sorted from the weakest channel to the strongest. After a start pulse it pulls entries one at a time from an upstream buffer through a read strobe. It adds each accepted entry to a running total. Each new entry is tested against that total, scaled by a constant power of two. An entry that stays below the scaled total belongs to the noise floor and is marked idle. The first entry that does not stay below it ends the scan, because a channel well above the accumulated noise is taken to carry a signal.

A small number of the weakest entries seed the running total. These entries are marked idle without a test. The result is a thermometer-shaped vector of idle flags indexed by sorted position, plus the highest idle position. A one-cycle done pulse marks the end of a scan. The results stay on the outputs until the next accepted start. Typical use is in a spectrum-sensing pipeline, after the sorter: it turns sorted energies into an adaptive occupied/idle decision, so no fixed noise-power threshold is needed.

Top module: `noise_floor_split`

## Requirements
- R1: While reset is held and in the first cycle after it, `done` and `rd_en` are low, and `idle_flags` and `boundary` are zero.
- R2: A `start` pulse seen while no scan is running clears all idle flags and the boundary. It raises `rd_en` in the next cycle.
- R3: Each sorted position takes one read cycle (`rd_en` high) and then one evaluate cycle, in which `rd_data` is used. `rd_en` is never high in two consecutive cycles. `done` appears exactly 2·m cycles after the start-accept cycle, where m is the number of entries read.
- R4: The first K_INIT positions (default 1) are always marked idle. Their energies seed the running sum.
- R5: A position k ≥ K_INIT is marked idle only if (sum of energies at positions 0..k−1) · 2^GAIN_SHIFT is strictly greater than the energy at position k. The default GAIN_SHIFT is 1. Equality counts as occupied.
- R6: The first failed test ends the scan. No further entries are read, and flags at that position and above stay clear. `rd_en` is high only inside a scan.
- R7: When every test passes, the scan reads exactly N_CH entries and stops. A scan never reads more than N_CH entries. The sum cannot overflow, even when every entry has the maximum value.
- R8: `boundary` holds the highest idle position. `idle_flags` bit i (bit 0 = weakest entry) is set exactly for positions 0..boundary.
- R9: `done` is high for exactly one cycle at the end of each scan. `boundary` and `idle_flags` are final in that cycle.
- R10: A `start` pulse during a running scan has no effect. The scan continues and produces the same result and read count as without the pulse.
- R11: After `done`, `idle_flags` and `boundary` hold their values until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a scan (accepted only when idle) |
| rd_en | output | 1 | Pops the next sorted energy from the upstream buffer |
| rd_data | input | E_W (16) | Energy returned one cycle after `rd_en` |
| boundary | output | $clog2(N_CH) (4) | Highest sorted position classified idle |
| idle_flags | output | N_CH (16) | Idle flag per sorted position, bit 0 = weakest |
| done | output | 1 | One-cycle pulse at scan end |

## Verification
The hardest case to reach from the ports is a start pulse that arrives in the middle of a scan. The block keeps no visible busy indication, so a wrongly accepted pulse would only show up as a shortened or restarted read sequence. The bench therefore issues an extra start a few cycles into a long scan, which reads every entry. It then checks both the read count and the latency against a scan without the pulse. The exact-tie case, where the scaled sum equals the next energy, and the all-maximum-value list are also built on purpose, because random clustered sets almost never hit them.

// File: rtl/noise_floor_split_pkg.sv
package noise_floor_split_pkg;
   typedef enum logic [1:0] {
      SCAN_IDLE = 2'd0,
      SCAN_READ = 2'd1,
      SCAN_EVAL = 2'd2
   } scan_state_e;
endpackage

// File: rtl/cusum_accum.sv
module cusum_accum #(
   parameter int E_W        = 16,
   parameter int SUM_W      = 20,
   parameter int GAIN_SHIFT = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             add_en,
   input  logic [E_W-1:0]   din,
   output logic [SUM_W-1:0] sum,
   output logic             above
);
   localparam int PAD_W = SUM_W - E_W;

   logic [SUM_W-1:0] sum_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sum_q <= '0;
      else if (clr)    sum_q <= '0;
      else if (add_en) sum_q <= sum_q + {{PAD_W{1'b0}}, din};
   end

   assign sum = sum_q;

   generate
      if (GAIN_SHIFT == 0) begin : g_direct
         assign above = sum_q > {{PAD_W{1'b0}}, din};
      end else begin : g_scaled
         localparam int SC_W = SUM_W + GAIN_SHIFT;
         logic [SC_W-1:0] scaled;
         assign scaled = {sum_q, {GAIN_SHIFT{1'b0}}};
         assign above  = scaled > {{(SC_W-E_W){1'b0}}, din};
      end
   endgenerate
endmodule

// File: rtl/idle_flag_bank.sv
module idle_flag_bank #(
   parameter int N_CH  = 16,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             set_en,
   input  logic [IDX_W-1:0] set_idx,
   output logic [N_CH-1:0]  flags
);
   generate
      for (genvar i = 0; i < N_CH; i++) begin : g_bit
         logic hit;
         assign hit = set_en && (set_idx == IDX_W'(i));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   flags[i] <= 1'b0;
            else if (clr) flags[i] <= 1'b0;
            else if (hit) flags[i] <= 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl
   import noise_floor_split_pkg::*;
#(
   parameter int N_CH   = 16,
   parameter int K_INIT = 1,
   parameter int IDX_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             above,
   output logic             rd_en,
   output logic             seed_clr,
   output logic             take,
   output logic [IDX_W-1:0] pos,
   output logic [IDX_W-1:0] boundary,
   output logic             done
);
   localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(N_CH - 1);
   localparam logic [IDX_W-1:0] SEED_CNT = IDX_W'(K_INIT);

   scan_state_e      st_q;
   logic [IDX_W-1:0] pos_q;
   logic             in_seed;
   logic             at_last;

   assign in_seed  = pos_q < SEED_CNT;
   assign at_last  = pos_q == LAST_POS;
   assign rd_en    = st_q == SCAN_READ;
   assign seed_clr = (st_q == SCAN_IDLE) && start;
   assign take     = (st_q == SCAN_EVAL) && (in_seed || above);
   assign pos      = pos_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= SCAN_IDLE;
         pos_q    <= '0;
         boundary <= '0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (st_q)
            SCAN_IDLE: begin
               if (start) begin
                  pos_q    <= '0;
                  boundary <= '0;
                  st_q     <= SCAN_READ;
               end
            end
            SCAN_READ: st_q <= SCAN_EVAL;
            SCAN_EVAL: begin
               if (take) boundary <= pos_q;
               if (take && !at_last) begin
                  pos_q <= pos_q + IDX_W'(1);
                  st_q  <= SCAN_READ;
               end else begin
                  st_q <= SCAN_IDLE;
                  done <= 1'b1;
               end
            end
            default: st_q <= SCAN_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/noise_floor_split.sv
module noise_floor_split #(
   parameter int N_CH       = 16,
   parameter int E_W        = 16,
   parameter int K_INIT     = 1,
   parameter int GAIN_SHIFT = 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   output logic                      rd_en,
   input  logic [E_W-1:0]            rd_data,
   output logic [$clog2(N_CH)-1:0]   boundary,
   output logic [N_CH-1:0]           idle_flags,
   output logic                      done
);
   localparam int IDX_W = $clog2(N_CH);
   localparam int SUM_W = E_W + IDX_W;

   initial begin : param_guard
      assert (N_CH >= 2) else $fatal(1, "N_CH must be at least 2");
      assert (K_INIT >= 1 && K_INIT < N_CH) else $fatal(1, "K_INIT out of range");
      assert (E_W >= 1 && GAIN_SHIFT >= 0 && GAIN_SHIFT <= 8)
         else $fatal(1, "width or gain out of range");
   end

   logic             seed_clr;
   logic             take;
   logic             above;
   logic [IDX_W-1:0] pos;
   logic [SUM_W-1:0] sum;

   scan_ctrl #(.N_CH(N_CH), .K_INIT(K_INIT), .IDX_W(IDX_W)) ctrl_i (
      .clk(clk), .rst_n(rst_n), .start(start), .above(above),
      .rd_en(rd_en), .seed_clr(seed_clr), .take(take), .pos(pos),
      .boundary(boundary), .done(done)
   );

   cusum_accum #(.E_W(E_W), .SUM_W(SUM_W), .GAIN_SHIFT(GAIN_SHIFT)) acc_i (
      .clk(clk), .rst_n(rst_n), .clr(seed_clr), .add_en(take),
      .din(rd_data), .sum(sum), .above(above)
   );

   idle_flag_bank #(.N_CH(N_CH), .IDX_W(IDX_W)) flags_i (
      .clk(clk), .rst_n(rst_n), .clr(seed_clr), .set_en(take),
      .set_idx(pos), .flags(idle_flags)
   );

   logic unused_sum;
   assign unused_sum = ^sum;
endmodule

// File: rtl/noise_floor_split_chk.sv
module noise_floor_split_chk #(
   parameter int N_CH   = 16,
   parameter int E_W    = 16,
   parameter int K_INIT = 1,
   parameter int IDX_W  = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             rd_en,
   input logic [E_W-1:0]   rd_data,
   input logic [IDX_W-1:0] boundary,
   input logic [N_CH-1:0]  idle_flags,
   input logic             done
);
   logic         busy_q;
   logic [IDX_W:0] rd_cnt;
   logic         accept;

   assign accept = start && (!busy_q || done);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         rd_cnt <= '0;
      end else begin
         if (accept)    busy_q <= 1'b1;
         else if (done) busy_q <= 1'b0;
         if (accept)     rd_cnt <= '0;
         else if (rd_en) rd_cnt <= rd_cnt + (IDX_W+1)'(1);
      end
   end

   function automatic logic [N_CH-1:0] thermo(input logic [IDX_W-1:0] b);
      logic [N_CH-1:0] t;
      for (int i = 0; i < N_CH; i++) t[i] = (IDX_W'(i) <= b);
      return t;
   endfunction

   // R2
   start_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (rd_en && idle_flags == '0));
   // R3
   read_pace_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> !rd_en);
   // R4
   seed_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (&idle_flags[K_INIT-1:0]));
   // R6
   read_in_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> busy_q);
   // R7
   read_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> (rd_cnt < (IDX_W+1)'(N_CH)));
   // R8
   flags_thermo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (idle_flags == thermo(boundary)));
   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R10
   no_clear_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !done) |=> ((idle_flags & $past(idle_flags)) == $past(idle_flags)));
   // R11
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && !start) |=> ($stable(idle_flags) && $stable(boundary)));

   logic unused_data;
   assign unused_data = ^rd_data;
endmodule

bind noise_floor_split noise_floor_split_chk #(
   .N_CH(N_CH), .E_W(E_W), .K_INIT(K_INIT), .IDX_W($clog2(N_CH))
) chk_i (
   .clk(clk), .rst_n(rst_n), .start(start), .rd_en(rd_en), .rd_data(rd_data),
   .boundary(boundary), .idle_flags(idle_flags), .done(done)
);

// File: tb/noise_floor_split_tb_top.sv
module noise_floor_split_tb_top;
   localparam int N  = 16;
   localparam int EW = 16;
   localparam int KI = 1;
   localparam int GS = 1;

   typedef struct {
      int bnd;
      int flags;
      int reads;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          rd_en;
   logic [EW-1:0] rd_data;
   logic [3:0]    boundary;
   logic [N-1:0]  idle_flags;
   logic          done;

   int   checks = 0;
   int   fails = 0;
   int   cyc = 0;
   int   start_cyc = 0;
   int   stim [N];
   logic [EW-1:0] mem [N];
   int   rd_ptr = 0;
   logic fifo_clr = 1'b0;
   exp_t exp_q [$];
   exp_t last_exp;

   always #2 clk = ~clk;

   noise_floor_split #(.N_CH(N), .E_W(EW), .K_INIT(KI), .GAIN_SHIFT(GS)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .rd_en(rd_en), .rd_data(rd_data),
      .boundary(boundary), .idle_flags(idle_flags), .done(done)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (fifo_clr) rd_ptr <= 0;
      else if (rd_en) begin
         rd_data <= mem[rd_ptr % N];
         rd_ptr  <= rd_ptr + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   // reference computed from R4/R5/R6/R7
   function automatic exp_t model();
      exp_t e;
      longint sum = 0;
      e.flags = 0; e.bnd = 0; e.reads = 0;
      for (int i = 0; i < KI; i++) begin
         e.flags |= (1 << i); e.bnd = i; sum += stim[i]; e.reads++;
      end
      for (int k = KI; k < N; k++) begin
         e.reads++;
         if ((sum << GS) > longint'(stim[k])) begin
            e.flags |= (1 << k); e.bnd = k; sum += stim[k];
         end else break;
      end
      return e;
   endfunction

   // monitor: pops expected results as done appears
   always begin
      @(negedge clk);
      if (done) begin
         exp_t e;
         if (exp_q.size() == 0) chk(1'b0, "R9 unexpected done", 1, 0);
         else begin
            e = exp_q.pop_front();
            chk(int'(boundary) == e.bnd, "R8 boundary", int'(boundary), e.bnd);
            chk(int'(idle_flags) == e.flags, "R5 idle flags", int'(idle_flags), e.flags);
            chk(idle_flags[0] == 1'b1, "R4 seed idle", int'(idle_flags[0]), 1);
            chk(rd_ptr == e.reads, "R6 R7 read count", rd_ptr, e.reads);
            chk(cyc - start_cyc == 2 * e.reads, "R3 latency", cyc - start_cyc, 2 * e.reads);
            last_exp = e;
         end
         @(negedge clk);
         chk(!done, "R9 done one cycle", int'(done), 0);
      end
   end

   task automatic run_scan(input bit mid_start);
      exp_q.push_back(model());
      for (int i = 0; i < N; i++) mem[i] = EW'(stim[i]);
      @(negedge clk);
      fifo_clr = 1'b1;
      @(negedge clk);
      fifo_clr = 1'b0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      start_cyc = cyc;
      chk(idle_flags == '0 && rd_en, "R2 clear and read", int'(idle_flags), 0);
      if (mid_start) begin
         repeat (3) @(negedge clk);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (exp_q.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic make_set(input int n_noise);
      int q[$];
      for (int i = 0; i < N; i++)
         q.push_back(i < n_noise ? $urandom_range(127, 100) : $urandom_range(65535, 30000));
      q.sort();
      for (int i = 0; i < N; i++) stim[i] = q[i];
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      chk(1'b0, "watchdog", cyc, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1
      chk(!done && !rd_en && idle_flags == '0 && boundary == '0, "R1 reset", int'(idle_flags), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!done && !rd_en && idle_flags == '0 && boundary == '0, "R1 after reset",
          int'(boundary), 0);

      for (int t = 0; t < 8; t++) begin
         make_set($urandom_range(N - 1, 1));
         run_scan(1'b0);
      end
      // R7 all noise, every test passes
      make_set(N); run_scan(1'b0);
      // R7 all maximum values: accumulator width
      for (int i = 0; i < N; i++) stim[i] = 65535;
      run_scan(1'b0);
      // R5 zero list: 0 > 0 fails
      for (int i = 0; i < N; i++) stim[i] = 0;
      run_scan(1'b0);
      // R5 exact tie at position 2: (100+100)*2 == 400
      for (int i = 0; i < N; i++) stim[i] = (i < 2) ? 100 : 400;
      run_scan(1'b0);
      // R6 single noise entry
      make_set(1); run_scan(1'b0);
      // R10 start mid-scan on a full-length scan
      make_set(N); run_scan(1'b1);
      // R11 hold after done
      repeat (6) @(negedge clk);
      chk(int'(idle_flags) == last_exp.flags && int'(boundary) == last_exp.bnd,
          "R11 hold", int'(idle_flags), last_exp.flags);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule